// File: doc/BRIEF.md
# Interrupt or Blinking Output Pin Mux

This block drives a single output pin that serves two purposes. When the interrupt-enable configuration bit is set, the pin presents the interrupt flag as an active-low interrupt line. When that bit is clear, the pin becomes a general-purpose output. Its level then comes from one of two configuration bits. With blinking off, the phase-0 bit alone decides the level. With blinking on, an externally toggled blink-phase input picks between the phase-0 bit and the phase-1 bit.

In general-purpose mode the pin can also be dimmed. A free-running counter with a period of 2^CNT_W clocks runs while PWM is enabled. For each period the pin carries its logic level for intensity+1 ticks and is held low for the remaining ticks. While PWM is disabled the counter sits at zero and the level is static. The pin is registered, so it follows its inputs with one clock of latency.

Top module: `irq_blink_pin`

## Requirements
- R1: During synchronous reset and on the first clock after it, the pin is high (interrupt line inactive).
- R2: With irq_en_i = 1, the pin equals the inverse of irq_flag_i sampled at the previous clock edge (active-low interrupt).
- R3: In interrupt mode, blink_en_i, blink_phase_i, pwm_en_i and intensity_i have no effect on the pin.
- R4: With irq_en_i = 0, blink_en_i = 0 and pwm_en_i = 0, the pin equals lvl_ph0_i from the previous edge, and lvl_ph1_i is ignored.
- R5: With irq_en_i = 0, blink_en_i = 1 and pwm_en_i = 0, the pin equals lvl_ph0_i when blink_phase_i was 0 and lvl_ph1_i when it was 1, both taken at the previous edge.
- R6: With pwm_en_i = 0, the general-purpose level is never gated by intensity_i, whatever value intensity_i has.
- R7: With pwm_en_i = 1 in general-purpose mode, a tick counter steps 0,1,...,15,0,... (CNT_W = 4). The pin carries its level on ticks where count <= intensity_i and is low on the other ticks. Intensity 15 therefore never gates the level, and intensity 0 passes it on one tick in 16.
- R8: While pwm_en_i = 0 the tick counter is held at 0, so the first clock after PWM is enabled is tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en_i | input | 1 | 1: interrupt line; 0: general-purpose output |
| blink_en_i | input | 1 | Enables phase selection of the level |
| lvl_ph1_i | input | 1 | General-purpose level for blink phase 1 |
| lvl_ph0_i | input | 1 | General-purpose level for blink phase 0 and for static mode |
| blink_phase_i | input | 1 | Current blink phase (slow toggle from outside) |
| irq_flag_i | input | 1 | Interrupt flag, 1 = pending |
| intensity_i | input | CNT_W | Global PWM intensity |
| pwm_en_i | input | 1 | Enables the PWM tick counter and dimming |
| pin_o | output | 1 | Registered pin level |

## Verification
The bench builds the block with its default CNT_W of 4, which gives a 16-tick period. Every one of the sixteen intensity values can therefore be swept, and each value is held over several whole periods, so both duty extremes and the counter wrap are reached. Random runs toggle PWM enable in the middle of a period to check that the counter restarts at tick 0. They also switch between interrupt and general-purpose modes while PWM is running.

// File: rtl/irq_blink_pin_pkg.sv
package irq_blink_pin_pkg;

    typedef struct packed {
        logic irq_en;
        logic blink_en;
        logic lvl_ph1;
        logic lvl_ph0;
    } pin_cfg_t;

    typedef enum logic [1:0] {
        MODE_IRQ    = 2'd0,
        MODE_STATIC = 2'd1,
        MODE_BLINK  = 2'd2
    } drive_mode_t;

    function automatic drive_mode_t decode_mode(input pin_cfg_t cfg);
        if (cfg.irq_en)        return MODE_IRQ;
        else if (cfg.blink_en) return MODE_BLINK;
        else                   return MODE_STATIC;
    endfunction

    function automatic logic phase_level(input pin_cfg_t cfg, input logic phase);
        return phase ? cfg.lvl_ph1 : cfg.lvl_ph0;
    endfunction

endpackage

// File: rtl/ibp_pwm_ticker.sv
module ibp_pwm_ticker #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || !en_i) cnt_o <= '0;
        else              cnt_o <= cnt_o + 1'b1;
    end

    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (en_i && cnt_o == CNT_MAX) |=> (cnt_o == '0));

    assert_step_R7: assert property (@(posedge clk) disable iff (rst)
        (en_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (cnt_o == '0));

endmodule

// File: rtl/ibp_level_sel.sv
module ibp_level_sel
    import irq_blink_pin_pkg::*;
(
    input  pin_cfg_t    cfg_i,
    input  logic        phase_i,
    output drive_mode_t mode_o,
    output logic        level_o
);
    always_comb begin
        mode_o = decode_mode(cfg_i);
        unique case (mode_o)
            MODE_BLINK:  level_o = phase_level(cfg_i, phase_i);
            MODE_STATIC: level_o = cfg_i.lvl_ph0;
            default:     level_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ibp_dimmer.sv
module ibp_dimmer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             level_i,
    input  logic             pwm_en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] intensity_i,
    output logic             level_o
);
    logic on_tick;

    always_comb begin
        on_tick = !pwm_en_i || (cnt_i <= intensity_i);
        level_o = level_i && on_tick;
    end

    always_comb begin
        if (!pwm_en_i) assert_static_pass_R6: assert (level_o == level_i);
    end
endmodule

// File: rtl/irq_blink_pin.sv
module irq_blink_pin
    import irq_blink_pin_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_en_i,
    input  logic             blink_en_i,
    input  logic             lvl_ph1_i,
    input  logic             lvl_ph0_i,
    input  logic             blink_phase_i,
    input  logic             irq_flag_i,
    input  logic [CNT_W-1:0] intensity_i,
    input  logic             pwm_en_i,
    output logic             pin_o
);
    pin_cfg_t         cfg;
    drive_mode_t      mode;
    logic             gp_level;
    logic             dim_level;
    logic [CNT_W-1:0] tick;
    logic             pin_d;

    assign cfg = '{irq_en: irq_en_i, blink_en: blink_en_i,
                   lvl_ph1: lvl_ph1_i, lvl_ph0: lvl_ph0_i};

    ibp_pwm_ticker #(.CNT_W(CNT_W)) ticker_i (
        .clk   (clk),
        .rst   (rst),
        .en_i  (pwm_en_i),
        .cnt_o (tick)
    );

    ibp_level_sel sel_i (
        .cfg_i   (cfg),
        .phase_i (blink_phase_i),
        .mode_o  (mode),
        .level_o (gp_level)
    );

    ibp_dimmer #(.CNT_W(CNT_W)) dim_i (
        .level_i     (gp_level),
        .pwm_en_i    (pwm_en_i),
        .cnt_i       (tick),
        .intensity_i (intensity_i),
        .level_o     (dim_level)
    );

    always_comb begin
        if (mode == MODE_IRQ) pin_d = !irq_flag_i;
        else                  pin_d = dim_level;
    end

    always_ff @(posedge clk) begin
        if (rst) pin_o <= 1'b1;
        else     pin_o <= pin_d;
    end

    assert_reset_high_R1: assert property (@(posedge clk)
        rst |=> pin_o);

    assert_irq_level_R2: assert property (@(posedge clk) disable iff (rst)
        irq_en_i |=> (pin_o == !$past(irq_flag_i)));

    assert_static_level_R4: assert property (@(posedge clk) disable iff (rst)
        (!irq_en_i && !blink_en_i && !pwm_en_i) |=> (pin_o == $past(lvl_ph0_i)));

    assert_blink_level_R5: assert property (@(posedge clk) disable iff (rst)
        (!irq_en_i && blink_en_i && !pwm_en_i)
        |=> (pin_o == ($past(blink_phase_i) ? $past(lvl_ph1_i) : $past(lvl_ph0_i))));

    assert_dark_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (!irq_en_i && pwm_en_i && tick > intensity_i) |=> !pin_o);

endmodule

// File: tb/irq_blink_pin_tb_top.sv
module irq_blink_pin_tb_top;
    localparam int CNT_W  = 4;
    localparam int PERIOD = 1 << CNT_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_en = 1'b1, blink_en = 1'b0, ph1 = 1'b0, ph0 = 1'b0;
    logic phase = 1'b0, flag = 1'b0, pwm_en = 1'b0;
    logic [CNT_W-1:0] inten = '0;
    logic pin;

    int n_checks = 0;
    int n_fail   = 0;
    int m_cnt    = 0;
    bit prev_pwm = 1'b0;

    always #10 clk = ~clk;

    irq_blink_pin #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .irq_en_i(irq_en), .blink_en_i(blink_en),
        .lvl_ph1_i(ph1), .lvl_ph0_i(ph0), .blink_phase_i(phase),
        .irq_flag_i(flag), .intensity_i(inten), .pwm_en_i(pwm_en), .pin_o(pin)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // One clock: predict at the edge from driven inputs, compare at negedge.
    task automatic tick();
        logic exp_v;
        logic lvl;
        string req;
        @(posedge clk);
        if (rst) begin
            exp_v = 1'b1; req = "R1";
        end else if (irq_en) begin
            exp_v = !flag;
            req = (pwm_en || blink_en) ? "R3" : "R2";
        end else begin
            lvl = (blink_en && phase) ? ph1 : ph0;
            if (pwm_en && m_cnt > int'(inten)) exp_v = 1'b0;
            else                               exp_v = lvl;
            if (pwm_en && !prev_pwm)  req = "R8";
            else if (pwm_en)          req = "R7";
            else if (inten != '0)     req = blink_en ? "R5/R6" : "R4/R6";
            else                      req = blink_en ? "R5" : "R4";
        end
        if (rst || !pwm_en) m_cnt = 0;
        else                m_cnt = (m_cnt + 1) % PERIOD;
        prev_pwm = pwm_en && !rst;
        @(negedge clk);
        n_checks++;
        if (pin !== exp_v) begin
            n_fail++;
            $display("FAIL %s: pin=%b expected=%b at %0t", req, pin, exp_v, $time);
        end
    endtask

    task automatic rand_cfg(bit allow_irq);
        irq_en   = allow_irq ? 1'($urandom % 2) : 1'b0;
        blink_en = 1'($urandom % 2);
        ph1      = 1'($urandom % 2);
        ph0      = 1'($urandom % 2);
        flag     = 1'($urandom % 2);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset holds pin high
        for (int i = 0; i < 3; i++) tick();
        rst = 1'b0;
        tick();
        // R2: interrupt mode, flag toggling
        for (int i = 0; i < 40; i++) begin flag = 1'($urandom % 2); tick(); end
        // R3: interrupt mode with PWM and blink stirred
        pwm_en = 1'b1; blink_en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            flag = 1'($urandom % 2); phase = 1'($urandom % 2);
            inten = CNT_W'($urandom); tick();
        end
        // R4/R6: static general-purpose with random intensity
        irq_en = 1'b0; blink_en = 1'b0; pwm_en = 1'b0;
        for (int i = 0; i < 40; i++) begin
            ph0 = 1'($urandom % 2); ph1 = 1'($urandom % 2);
            inten = CNT_W'($urandom); tick();
        end
        // R5: blink with phase toggles
        blink_en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            if (i % 5 == 0) phase = ~phase;
            ph0 = 1'($urandom % 2); ph1 = 1'($urandom % 2); tick();
        end
        // R7/R8: sweep every intensity over three periods, level held high
        blink_en = 1'b0; ph0 = 1'b1;
        for (int k = 0; k < PERIOD; k++) begin
            pwm_en = 1'b0; inten = CNT_W'(k); tick();
            pwm_en = 1'b1;
            for (int i = 0; i < 3 * PERIOD; i++) tick();
        end
        // Mixed random traffic, PWM toggled mid-period
        for (int i = 0; i < 1500; i++) begin
            if (i % 23 == 0) rand_cfg(1'b1);
            if (i % 37 == 0) pwm_en = ~pwm_en;
            if (i % 7 == 0)  phase = ~phase;
            if (i % 61 == 0) inten = CNT_W'($urandom);
            tick();
        end
        // R1: reset again in the middle of PWM activity
        irq_en = 1'b0; ph0 = 1'b0; pwm_en = 1'b1;
        rst = 1'b1; tick(); tick();
        rst = 1'b0; ph0 = 1'b1; inten = '0;
        for (int i = 0; i < 2 * PERIOD; i++) tick();
        summary();
        $finish;
    end
endmodule